// File: doc/BRIEF.md
# Cascaded 20-to-1 Parallel-to-Serial Converter

This block takes a 20-bit parallel word and sends it out as a serial bit stream, lowest index first, one bit per cycle of the bit clock. The conversion runs in three stages. First, four identical 5-to-1 lane units each pick one of their five bits in turn. Next, a 4-to-2 stage merges the lanes into an even path and an odd path. Last, a 2-to-1 stage interleaves those two paths into the single output. Each 5-to-1 unit steers its multiplexer with a one-hot select. That select is a registered decode of a divide-by-five counter, sampled once per lane period. Each 2-to-1 cell holds its second input for half its period in a delay register, so both inputs are presented in order.

The slower rates run as clock enables inside one bit-rate clock domain. A two-bit phase counter sets the lane period of four bit cycles. A divide-by-five counter sets the frame of twenty cycles. A word is taken only at the frame boundary. The boundary is the first clock edge after reset is released, and every twentieth edge after that. If the strobe is high at that edge, the word is accepted. If it is low, the frame is filled with zeros, so an idle link stays low.

Top module: `ser20_cascade`

## Requirements
- R1: While reset is high, and after it until the first accepted word reaches the output, `ser_o` is 0.
- R2: Take the boundary edge that accepts a word as edge E. Bit n of that word (n = 0..19) is on `ser_o` after edge E+3+n and stays there for one cycle.
- R3: The word is sampled only at frame boundaries. These are the first edge after reset is released and every 20th edge after it. Changes on `word_i` and pulses on `word_stb_i` at any other edge have no effect on the output.
- R4: A frame boundary with `word_stb_i` low produces 20 consecutive zero bits on `ser_o` in that frame's output slots.
- R5: Words accepted at consecutive boundaries come out back to back, with no gap or repeated bit between them.
- R6: The lane selects are one-hot at all times. They advance only once per four-cycle lane period, so each lane bit is held for four cycles.
- R7: A reset asserted in the middle of a stream drops the word in flight. The output is 0 after the reset edge, and framing restarts so that the first edge after release is again a boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| word_i | input | 20 | Parallel word; bit 0 is sent first |
| word_stb_i | input | 1 | Marks `word_i` as valid at a frame boundary |
| ser_o | output | 1 | Serial output, one bit per clock |

## Verification
The bench drives junk strobes and changing word values between boundaries. A design that sampled the word at the wrong edge, or that let a late word change leak into a lane, would show corrupted bits in the middle of a frame. Back-to-back words with alternating and walking patterns expose swapped lanes, swapped even/odd paths, or a 2-to-1 cell whose delay register is off by half a period: each of these shows up as misordered or repeated bits. Idle frames and a reset in the middle of a frame check that stale hold contents never reappear, and that framing restarts at the first edge after release.

// File: rtl/ser20_pkg.sv
package ser20_pkg;
    localparam int WORD_W = 20;
    localparam int LANES  = 4;
    localparam int SLOTS  = WORD_W / LANES;
    localparam int PH_W   = $clog2(LANES);
    localparam int DIV_W  = $clog2(SLOTS);

    typedef logic [SLOTS-1:0] sel_t;

    typedef struct packed {
        logic load;
        logic lane;
        logic pair_a;
        logic pair_b;
        logic fin_a;
        logic fin_b;
    } strobes_t;

    function automatic sel_t onehot_of(input logic [DIV_W-1:0] idx);
        return sel_t'(1) << idx;
    endfunction
endpackage

// File: rtl/ser20_ctrl.sv
module ser20_ctrl
    import ser20_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    output strobes_t stb_o,
    output sel_t     sel_o
);
    logic [PH_W-1:0]  ph_q;
    logic [DIV_W-1:0] div_q;
    sel_t             sel_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q  <= '0;
            div_q <= '0;
            sel_q <= onehot_of('0);
        end else begin
            ph_q <= ph_q + PH_W'(1);
            if (ph_q == PH_W'(LANES - 1))
                div_q <= (div_q == DIV_W'(SLOTS - 1)) ? '0 : div_q + DIV_W'(1);
            // the divided count is resampled by the fast clock into a select
            sel_q <= onehot_of(div_q);
        end
    end

    always_comb begin
        stb_o.load   = (ph_q == '0) && (div_q == '0);
        stb_o.lane   = (ph_q == PH_W'(1));
        stb_o.pair_a = (ph_q == PH_W'(2));
        stb_o.pair_b = (ph_q == '0);
        stb_o.fin_a  = ph_q[0];
        stb_o.fin_b  = !ph_q[0];
    end

    assign sel_o = sel_q;

    // R6
    sel_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(sel_q));
    // R6
    sel_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q == PH_W'(1)) |=> $stable(sel_q));
    // R3
    div_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        div_q < DIV_W'(SLOTS));
endmodule

// File: rtl/ser20_lane_bank.sv
module ser20_lane_bank
    import ser20_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic              strobe_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              lane_en_i,
    input  sel_t              sel_i,
    output logic [LANES-1:0]  lane_o
);
    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       hold_q <= '0;
        else if (load_i) hold_q <= strobe_i ? word_i : '0;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [SLOTS-1:0] slot_bits;
        logic             lane_q;
        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            assign slot_bits[k] = hold_q[j + LANES * k];
        end
        always_ff @(posedge clk_i) begin
            if (rst_i)          lane_q <= 1'b0;
            else if (lane_en_i) lane_q <= |(slot_bits & sel_i);
        end
        assign lane_o[j] = lane_q;
    end

    // R3
    hold_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(hold_q));
    // R4
    idle_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && !strobe_i) |=> (hold_q == '0));
endmodule

// File: rtl/ser20_pair.sv
module ser20_pair (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_a_i,
    input  logic en_b_i,
    input  logic a_i,
    input  logic b_i,
    output logic y_o
);
    logic dly_q;
    logic y_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dly_q <= 1'b0;
            y_q   <= 1'b0;
        end else if (en_a_i) begin
            y_q   <= a_i;
            dly_q <= b_i;
        end else if (en_b_i) begin
            y_q <= dly_q;
        end
    end

    assign y_o = y_q;

    // R2
    phase_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(en_a_i && en_b_i));
endmodule

// File: rtl/ser20_cascade.sv
module ser20_cascade
    import ser20_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_stb_i,
    output logic              ser_o
);
    strobes_t         stb;
    sel_t             sel;
    logic [LANES-1:0] lane;
    logic             even_path;
    logic             odd_path;

    ser20_ctrl u_ctrl (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .stb_o (stb),
        .sel_o (sel)
    );

    ser20_lane_bank u_bank (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (stb.load),
        .strobe_i  (word_stb_i),
        .word_i    (word_i),
        .lane_en_i (stb.lane),
        .sel_i     (sel),
        .lane_o    (lane)
    );

    ser20_pair u_even (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_a_i (stb.pair_a),
        .en_b_i (stb.pair_b),
        .a_i    (lane[0]),
        .b_i    (lane[2]),
        .y_o    (even_path)
    );

    ser20_pair u_odd (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_a_i (stb.pair_a),
        .en_b_i (stb.pair_b),
        .a_i    (lane[1]),
        .b_i    (lane[3]),
        .y_o    (odd_path)
    );

    ser20_pair u_final (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_a_i (stb.fin_a),
        .en_b_i (stb.fin_b),
        .a_i    (even_path),
        .b_i    (odd_path),
        .y_o    (ser_o)
    );

    // R1
    post_reset_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !ser_o);
    // R7
    restart_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> stb.load);
endmodule

// File: tb/ser20_cascade_tb_top.sv
module ser20_cascade_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] word = '0;
    logic         strb = 1'b0;
    logic         ser;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    started = 0;
    string cur_tag = "R1";
    string rst_tag = "R1";

    bit    q_bits[$];
    string q_tags[$];
    int    fc = 0;
    logic  exp_bit = 1'b0;
    string exp_tag = "R1";

    ser20_cascade dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .word_i     (word),
        .word_stb_i (strb),
        .ser_o      (ser)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference model: queue of expected serial bits, 3-cycle latency
    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            q_bits.delete();
            q_tags.delete();
            for (int i = 0; i < 3; i++) begin
                q_bits.push_back(1'b0);
                q_tags.push_back(rst_tag);
            end
            fc = 0;
            exp_bit = 1'b0;
            exp_tag = rst_tag;
        end else begin
            if (fc == 0) begin
                for (int i = 0; i < W; i++) begin
                    q_bits.push_back(strb ? word[i] : 1'b0);
                    q_tags.push_back(cur_tag);
                end
            end
            fc = (fc + 1) % W;
            exp_bit = q_bits.pop_front();
            exp_tag = q_tags.pop_front();
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (ser !== exp_bit) begin
                errors++;
                $display("FAIL %s: ser_o=%b expected %b at %0t", exp_tag, ser, exp_bit, $time);
            end
        end
    end

    // one frame: boundary value then 19 cycles of optional junk (R3)
    task automatic frame(input bit en, input logic [W-1:0] w, input string tag, input bit junk);
        strb = en;
        word = w;
        cur_tag = tag;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < W - 1; i++) begin
            strb = junk ? 1'($urandom_range(0, 1)) : 1'b0;
            word = junk ? W'($urandom) : w;
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input int n, input string tag);
        @(negedge clk);
        rst_tag = tag;
        rst = 1'b1;
        strb = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(4, "R1");
        // R1: no word yet, output stays low
        frame(1'b0, 20'hFFFFF, "R1", 1'b0);
        // R2 / R5: back-to-back patterns
        frame(1'b1, 20'hFFFFF, "R2", 1'b0);
        frame(1'b1, 20'h00001, "R2", 1'b0);
        frame(1'b1, 20'h80000, "R2", 1'b0);
        frame(1'b1, 20'hAAAAA, "R5", 1'b0);
        frame(1'b1, 20'h55555, "R5", 1'b0);
        frame(1'b1, 20'h12345, "R5", 1'b0);
        // R6: one bit per lane slot exposes lane hold time
        frame(1'b1, 20'h0F0F0, "R6", 1'b0);
        frame(1'b1, 20'hF000F, "R6", 1'b0);
        // R3: junk strobes and word changes between boundaries
        frame(1'b1, 20'hC3A5E, "R3", 1'b1);
        frame(1'b1, 20'h7B1D2, "R3", 1'b1);
        // R4: idle frame with junk around it
        frame(1'b0, 20'hFFFFF, "R4", 1'b1);
        frame(1'b1, 20'h9E37B, "R5", 1'b0);
        // R7: reset in the middle of a frame
        strb = 1'b1;
        word = 20'hFFFFF;
        cur_tag = "R7";
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        rst_tag = "R7";
        rst = 1'b1;
        strb = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        rst = 1'b0;
        frame(1'b1, 20'h3C96A, "R7", 1'b0);
        frame(1'b1, 20'hFFFFF, "R7", 1'b0);
        frame(1'b0, 20'h00000, "R4", 1'b0);
        frame(1'b0, 20'h00000, "R4", 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule